// File: doc/BRIEF.md
# Timer Event Flags and Trigger Sequencer

This block keeps the sticky event flags of a timer/PWM peripheral: one overflow flag and `N_CH` channel flags. Each flag is raised by a single-cycle set strobe coming from the counter or the compare/capture logic. Software clears a flag by writing a one to it. When the flag's DMA enable is on, a DMA completion pulse for that event clears it as well. From each flag the block forms a DMA request and an interrupt request, each gated by that event's own enable bit.

The block also drives timing signals for other peripherals. The overflow trigger goes high when the overflow flag is raised and stays high until the counter next advances. Each channel drives a pre-trigger and a trigger that step forward on counter-increment strobes, not on clock cycles. The pre-trigger rises when the channel flag is raised. The trigger joins it on the next increment, and both fall on the increment after that.

All event vectors use one index layout: bit 0 is the overflow event and bit k+1 is channel k.

Top module: `tmr_evt_flags`

## Requirements
- R1: `dma_req_o[e]` is high exactly when event e's flag is 1 and `dma_en_i[e]` is 1.
- R2: `irq_o[e]` is high exactly when event e's flag is 1 and `irq_en_i[e]` is 1, whatever the value of `dma_en_i[e]`.
- R3: A pulse on `evt_set_i[e]` sets flag e, and the flag is visible on the outputs in the cycle after the clock edge. Bit 0 is overflow and bit k+1 is channel k.
- R4: A pulse on `evt_w1c_i[e]` clears flag e, whether DMA is enabled or not.
- R5: A pulse on `evt_dma_done_i[e]` clears flag e when `dma_en_i[e]` is 1 and has no effect when it is 0.
- R6: When a set pulse meets a clear (write-one or DMA done) on the same edge, the flag ends at 1.
- R7: `ovf_trig_o` rises after the edge that sets the overflow flag, including when an increment falls on the same edge, and it falls after the next edge that carries `cnt_inc_i`.
- R8: `ch_pretrig_o[k]` rises after the edge that carries a set pulse for channel k while that channel's sequence is idle.
- R9: `ch_trig_o[k]` rises after the first edge with `cnt_inc_i` that occurs after `ch_pretrig_o[k]` is high.
- R10: After the trigger is high, the next edge with `cnt_inc_i` drops both `ch_trig_o[k]` and `ch_pretrig_o[k]`.
- R11: A channel set pulse that arrives while the channel's sequence is running neither restarts nor extends it.
- R12: While `rst_ni` is low, all flags, requests and triggers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_inc_i | input | 1 | Counter increment strobe |
| evt_set_i | input | N_CH+1 | Per-event flag set pulses |
| evt_w1c_i | input | N_CH+1 | Per-event write-one-to-clear strobes |
| evt_dma_done_i | input | N_CH+1 | Per-event DMA completion pulses |
| dma_en_i | input | N_CH+1 | Per-event DMA enable |
| irq_en_i | input | N_CH+1 | Per-event interrupt enable |
| dma_req_o | output | N_CH+1 | Per-event DMA request |
| irq_o | output | N_CH+1 | Per-event interrupt request |
| ovf_trig_o | output | 1 | Overflow trigger |
| ch_pretrig_o | output | N_CH | Per-channel pre-trigger |
| ch_trig_o | output | N_CH | Per-channel trigger |

## Verification
Two kinds of collision can fall in the same cycle. A flag's set can coincide with its clear, through a write-one or a DMA completion. A channel or overflow set can coincide with a counter increment. Directed steps force both on one edge: set together with write-one, set together with DMA done, and overflow set together with an increment. A random phase then drives sparse overlapping strobes for thousands of cycles. On every clock the outputs are compared with a behavioural model that resolves these collisions by the stated priorities: set wins over clear, and a new set is ignored while a sequence is running.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PRE  = 2'd1,
    SEQ_TRIG = 2'd2
  } seq_st_e;
endpackage

// File: rtl/evt_flag.sv
module evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic w1c_i,
  input  logic dma_done_i,
  input  logic dma_en_i,
  input  logic irq_en_i,
  output logic dma_req_o,
  output logic irq_o
);
  logic flag_q;
  logic clr;

  // DMA completion only counts when DMA is enabled for this event
  assign clr = w1c_i | (dma_en_i & dma_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign dma_req_o = flag_q & dma_en_i;
  assign irq_o     = flag_q & irq_en_i;
endmodule

// File: rtl/ovf_trig.sv
module ovf_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic inc_i,
  output logic trig_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    trig_q <= 1'b0;
    else if (set_i) trig_q <= 1'b1;
    else if (inc_i) trig_q <= 1'b0;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/ch_trig_seq.sv
module ch_trig_seq
  import tmr_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic inc_i,
  output logic pretrig_o,
  output logic trig_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (set_i) st_d = SEQ_PRE;
      SEQ_PRE:  if (inc_i) st_d = SEQ_TRIG;
      SEQ_TRIG: if (inc_i) st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign pretrig_o = (st_q != SEQ_IDLE);
  assign trig_o    = (st_q == SEQ_TRIG);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter  int N_CH  = 4,
  localparam int N_EVT = N_CH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_inc_i,
  input  logic [N_EVT-1:0] evt_set_i,
  input  logic [N_EVT-1:0] evt_w1c_i,
  input  logic [N_EVT-1:0] evt_dma_done_i,
  input  logic [N_EVT-1:0] dma_en_i,
  input  logic [N_EVT-1:0] irq_en_i,
  output logic [N_EVT-1:0] dma_req_o,
  output logic [N_EVT-1:0] irq_o,
  output logic             ovf_trig_o,
  output logic [N_CH-1:0]  ch_pretrig_o,
  output logic [N_CH-1:0]  ch_trig_o
);
  localparam int OVF_IDX = 0;

  for (genvar e = 0; e < N_EVT; e++) begin : g_flag
    evt_flag u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (evt_set_i[e]),
      .w1c_i      (evt_w1c_i[e]),
      .dma_done_i (evt_dma_done_i[e]),
      .dma_en_i   (dma_en_i[e]),
      .irq_en_i   (irq_en_i[e]),
      .dma_req_o  (dma_req_o[e]),
      .irq_o      (irq_o[e])
    );
  end

  ovf_trig u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set_i[OVF_IDX]),
    .inc_i  (cnt_inc_i),
    .trig_o (ovf_trig_o)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    ch_trig_seq u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (evt_set_i[k+1]),
      .inc_i     (cnt_inc_i),
      .pretrig_o (ch_pretrig_o[k]),
      .trig_o    (ch_trig_o[k])
    );
  end
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
  parameter  int N_CH  = 4,
  localparam int N_EVT = N_CH + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_inc_i,
  input logic [N_EVT-1:0] evt_set_i,
  input logic [N_EVT-1:0] evt_w1c_i,
  input logic [N_EVT-1:0] evt_dma_done_i,
  input logic [N_EVT-1:0] dma_en_i,
  input logic [N_EVT-1:0] irq_en_i,
  input logic [N_EVT-1:0] dma_req_o,
  input logic [N_EVT-1:0] irq_o,
  input logic             ovf_trig_o,
  input logic [N_CH-1:0]  ch_pretrig_o,
  input logic [N_CH-1:0]  ch_trig_o
);
  AST_DMA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~dma_en_i) == '0); // R1
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_en_i) == '0); // R2
  AST_OVF_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i[0] |=> ovf_trig_o); // R7
  AST_TRIG_NEEDS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_trig_o & ~ch_pretrig_o) == '0); // R9

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    AST_SET_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_set_i[e] |=> (irq_o[e] || !irq_en_i[e])); // R6
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    AST_PRE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_set_i[k+1] && !ch_pretrig_o[k]) |=> ch_pretrig_o[k]); // R8
    AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_pretrig_o[k] && !cnt_inc_i) |=> (ch_pretrig_o[k] && ch_trig_o[k] == $past(ch_trig_o[k]))); // R11
    AST_SEQ_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_trig_o[k] && cnt_inc_i) |=> !ch_pretrig_o[k]); // R10
  end
endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(.N_CH(N_CH)) chk_i (.*);

// File: tb/tmr_evt_flags_tb_top.sv
module tmr_evt_flags_tb_top;
  localparam int CLK_P = 10;
  localparam int N_CH  = 4;
  localparam int N_EVT = N_CH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_inc = 1'b0;
  logic [N_EVT-1:0] set_v = '0, w1c_v = '0, done_v = '0, dma_en = '0, irq_en = '0;
  logic [N_EVT-1:0] dma_req, irq;
  logic ovf_trig;
  logic [N_CH-1:0] pre, trig;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_evt_flags #(.N_CH(N_CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_inc_i(cnt_inc),
    .evt_set_i(set_v), .evt_w1c_i(w1c_v), .evt_dma_done_i(done_v),
    .dma_en_i(dma_en), .irq_en_i(irq_en),
    .dma_req_o(dma_req), .irq_o(irq), .ovf_trig_o(ovf_trig),
    .ch_pretrig_o(pre), .ch_trig_o(trig)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_flag[N_EVT];
  bit m_ovt;
  int m_st[N_CH]; // 0 idle, 1 pre, 2 trig

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[e]) m_flag[e] = 0;
      foreach (m_st[k]) m_st[k] = 0;
      m_ovt = 0;
    end else begin
      for (int e = 0; e < N_EVT; e++) begin
        if (set_v[e]) m_flag[e] = 1;
        else if (w1c_v[e] || (dma_en[e] && done_v[e])) m_flag[e] = 0;
      end
      if (set_v[0]) m_ovt = 1;
      else if (cnt_inc) m_ovt = 0;
      for (int k = 0; k < N_CH; k++) begin
        case (m_st[k])
          0: if (set_v[k+1]) m_st[k] = 1;
          1: if (cnt_inc) m_st[k] = 2;
          default: if (cnt_inc) m_st[k] = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [N_EVT-1:0] ed, ei;
    logic [N_CH-1:0] ep, et;
    if (rst_n && !finished) begin
      for (int e = 0; e < N_EVT; e++) begin
        ed[e] = m_flag[e] & dma_en[e];
        ei[e] = m_flag[e] & irq_en[e];
      end
      for (int k = 0; k < N_CH; k++) begin
        ep[k] = (m_st[k] != 0);
        et[k] = (m_st[k] == 2);
      end
      chk("R1 model dma_req", 32'(dma_req), 32'(ed));
      chk("R2 model irq", 32'(irq), 32'(ei));
      chk("R7 model ovf_trig", 32'(ovf_trig), 32'(m_ovt));
      chk("R8 model pretrig", 32'(pre), 32'(ep));
      chk("R9 model trig", 32'(trig), 32'(et));
    end
  end

  // drive phase: 1 time unit after the rising edge
  task automatic tick();
    @(posedge clk);
    #1;
    set_v = '0; w1c_v = '0; done_v = '0; cnt_inc = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    irq_en = '1;
    dma_en = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset irq", 32'(irq), 0);
    chk("R12 reset pre/trig", 32'({pre, trig, ovf_trig}), 0);
    rst_n = 1'b1;
    tick();
    chk("R12 after reset dma_req", 32'(dma_req), 0);

    // channel 0 = event index 1
    set_v = 5'b00010; tick();
    chk("R3 flag set irq", 32'(irq), 32'h2);
    chk("R8 pretrig rise", 32'(pre[0]), 1);
    chk("R9 trig before inc", 32'(trig[0]), 0);

    done_v = 5'b00010; tick();
    chk("R5 dma done ignored", 32'(irq), 32'h2);

    cnt_inc = 1'b1; tick();
    chk("R9 trig after inc", 32'({pre[0], trig[0]}), 32'h3);

    set_v = 5'b00010; tick();
    chk("R11 set while running", 32'({pre[0], trig[0]}), 32'h3);

    cnt_inc = 1'b1; tick();
    chk("R10 both drop", 32'({pre[0], trig[0]}), 0);
    tick();
    chk("R11 no restart", 32'(pre[0]), 0);

    w1c_v = 5'b00010; tick();
    chk("R4 w1c clears", 32'(irq), 0);

    dma_en = '1;
    set_v = 5'b00100; tick();
    chk("R1 dma_req", 32'(dma_req), 32'h4);
    irq_en = '0; #1;
    chk("R2 irq off", 32'(irq), 0);
    chk("R2 dma kept", 32'(dma_req), 32'h4);
    irq_en = '1;

    done_v = 5'b00100; tick();
    chk("R5 dma done clears", 32'(dma_req), 0);

    set_v = 5'b01000; w1c_v = 5'b01000; tick();
    chk("R6 set beats w1c", 32'(dma_req[3]), 1);
    set_v = 5'b01000; done_v = 5'b01000; tick();
    chk("R6 set beats done", 32'(dma_req[3]), 1);

    set_v = 5'b00001; cnt_inc = 1'b1; tick();
    chk("R7 ovf trig with inc", 32'(ovf_trig), 1);
    tick();
    chk("R7 ovf trig holds", 32'(ovf_trig), 1);
    cnt_inc = 1'b1; tick();
    chk("R7 ovf trig drops", 32'(ovf_trig), 0);
    chk("R3 ovf flag stays", 32'(dma_req[0]), 1);

    w1c_v = '1; tick();
    chk("R4 w1c all", 32'(dma_req), 0);

    // random phase: sparse overlapping strobes, compared by the model
    for (int i = 0; i < 4000; i++) begin
      for (int e = 0; e < N_EVT; e++) begin
        set_v[e]  = ($urandom % 6) == 0;
        w1c_v[e]  = ($urandom % 7) == 0;
        done_v[e] = ($urandom % 5) == 0;
      end
      cnt_inc = ($urandom % 3) == 0;
      if ((i % 250) == 0) begin
        dma_en = N_EVT'($urandom);
        irq_en = N_EVT'($urandom);
      end
      tick();
    end

    rst_n = 1'b0; #1;
    chk("R12 async reset", 32'({dma_req, irq, ovf_trig, pre, trig}), 0);
    @(negedge clk);
    finish_run();
  end
endmodule